// File: doc/BRIEF.md
# I2C Channel-Code and Parallel Port Slave

This block is an I2C target that answers on one 7-bit address and serves two jobs. It keeps an 8-bit code register for each converter channel and drives every code out as a parallel bus toward an external converter. It also runs a parallel I/O port: the master can write the port's output latch, and it can read the port's input pins. A static strap, `more_dac`, divides the resources between two set-ups. When low, the block has four code channels and an 8-bit port. When high, it has eight code channels and a 4-bit port.

A write frame is START, address with R/W=0, a selection byte, a data byte, then STOP. The slave acknowledges each of those bytes. The selection byte chooses either one code channel or the port latch. A read frame is START, address with R/W=1, then one byte that the slave returns from the port inputs. The master then gives its acknowledge bit and a STOP. SCL and SDA are brought into the system clock domain with two flip-flops. START and STOP are found as SDA edges while SCL is high. The slave pulls SDA low through `sda_oe`.

The controller is a state machine with these states:
- `ST_IDLE`: waits for a START.
- `ST_ADDR`: shifts in the address byte.
- `ST_ADDR_ACK`: drives the acknowledge for the address.
- `ST_CMD`: shifts in the selection byte.
- `ST_CMD_ACK`: drives the acknowledge for the selection byte.
- `ST_DATA`: shifts in the data byte.
- `ST_DATA_ACK`: drives the acknowledge for the data byte.
- `ST_RD`: shifts the port byte out.
- `ST_HOLD`: keeps SDA released until the next START or STOP.

Its transitions are:
- Any state goes to `ST_IDLE` on STOP, and to `ST_ADDR` on START.
- `ST_ADDR` goes to `ST_ADDR_ACK` on an address match, or to `ST_HOLD` on a mismatch.
- `ST_ADDR_ACK` goes to `ST_CMD` for a write, or to `ST_RD` for a read.
- `ST_CMD` goes to `ST_CMD_ACK`, then to `ST_DATA`.
- `ST_DATA` goes to `ST_DATA_ACK`, then to `ST_HOLD`, and the register update happens at that step.
- `ST_RD` goes to `ST_HOLD` after eight bits.

All state changes other than START and STOP happen on SCL falling edges.

Top module: `dacx_i2c_slave`

## Requirements
- R1: After reset all channel codes and the port output latch are 0, and `sda_oe` is 0.
- R2: The slave address is `{5'b10110, addr_sel}`. On a match the slave pulls SDA low for the acknowledge slot after the address byte, and after each byte it receives in a write frame.
- R3: On a non-matching address the slave never asserts `sda_oe` before the next START, and it changes no register.
- R4: In a write frame, selection value k (1 to N) loads the data byte into channel k, which appears on `dac_code[8k-1:8k-8]`. The output changes only after the SCL falling edge that ends the data byte's acknowledge slot.
- R5: N is 4 when `more_dac`=0 and 8 when `more_dac`=1. Channels above N are not written.
- R6: Selection value 0 loads the data byte into `exp_out`. When `more_dac`=1, data bits 7:4 are ignored and `exp_out[7:4]` is loaded with 0.
- R7: A read frame returns `exp_in` MSB first. When `more_dac`=1, the upper four returned bits are 0.
- R8: `exp_in` is sampled once, on the SCL falling edge that ends the address acknowledge of a read. Later changes on `exp_in` do not alter the returned byte.
- R9: A STOP or START that arrives before the data byte's acknowledge slot has ended aborts the frame, and no register changes.
- R10: A selection value greater than N is still acknowledged, and the data byte that follows it is discarded.
- R11: A repeated START begins a fresh address phase, and a complete frame that follows it is applied normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_sel | input | 2 | Low address bits from the select pins |
| more_dac | input | 1 | Static strap: 0 gives 4 channels and an 8-bit port, 1 gives 8 channels and a 4-bit port |
| exp_in | input | 8 | Parallel port input pins |
| exp_out | output | 8 | Parallel port output latch |
| dac_code | output | 64 | Channel codes; channel k is on bits 8k-1 down to 8k-8 |

## Verification
The assertions assume the master keeps to the bus rules:
- SDA changes only while SCL is low, except for START and STOP.
- SCL high and low phases each last well beyond the three-cycle synchronizer lag.
- `more_dac` and `addr_sel` stay fixed while a frame is in progress.

The bench master moves SDA only a quarter bit after SCL has fallen, holds each phase for ten system clocks, and changes the strap only between frames. Repeated START and mid-frame STOP are produced only with SCL low before the SDA edge, so every bus event the design sees is a legal one.

// File: rtl/dacx_pkg.sv
package dacx_pkg;
    localparam int BYTE_BITS = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_RD,
        ST_HOLD
    } dacx_state_e;
endpackage

// File: rtl/dacx_line_sync.sv
module dacx_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic [1:0] scl_pipe;
    logic [1:0] sda_pipe;
    logic       scl_q;
    logic       sda_q;
    logic       scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= 2'b11;
            sda_pipe <= 2'b11;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[0], scl_i};
            sda_pipe <= {sda_pipe[0], sda_i};
            scl_q    <= scl_pipe[1];
            sda_q    <= sda_pipe[1];
        end
    end

    assign scl_s     = scl_pipe[1];
    assign sda_s     = sda_pipe[1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
    assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/dacx_ctrl.sv
module dacx_ctrl
    import dacx_pkg::*;
#(
    parameter int          SEL_W   = 2,
    parameter int          HI_W    = 7 - SEL_W,
    parameter logic [HI_W-1:0] ADDR_HI = 5'b10110,
    parameter int          CODE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic [SEL_W-1:0]  addr_sel,
    input  logic              more_dac,
    input  logic [CODE_W-1:0] rd_word,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [7:0]        wr_sel,
    output logic [CODE_W-1:0] wr_data
);
    localparam logic [3:0] BYTE_END = 4'(BYTE_BITS);
    localparam logic [3:0] LAST_TX  = 4'(BYTE_BITS - 1);
    localparam logic [3:0] HALF     = 4'(BYTE_BITS / 2);

    dacx_state_e state;
    logic [3:0]  cnt;
    logic [7:0]  shreg;
    logic [7:0]  cmd;
    logic [7:0]  tx;
    logic        rw;
    logic        shifting;
    logic        own_match;

    assign shifting  = (state == ST_ADDR || state == ST_CMD || state == ST_DATA)
                       && scl_rise && (cnt != BYTE_END);
    assign own_match = (shreg[7:1] == {ADDR_HI, addr_sel});

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            shreg <= '0;
            cmd   <= '0;
            tx    <= '0;
            rw    <= 1'b0;
            wr_en <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (bus_stop) begin
                state <= ST_IDLE;
            end else if (bus_start) begin
                state <= ST_ADDR;
                cnt   <= '0;
            end else begin
                if (shifting) begin
                    shreg <= {shreg[6:0], sda_s};
                    cnt   <= cnt + 4'd1;
                end
                unique case (state)
                    ST_IDLE, ST_HOLD: begin
                    end
                    ST_ADDR: begin
                        if (scl_fall && cnt == BYTE_END) begin
                            cnt <= '0;
                            if (own_match) begin
                                rw    <= shreg[0];
                                state <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_HOLD;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (rw) begin
                                tx    <= rd_word;
                                state <= ST_RD;
                            end else begin
                                state <= ST_CMD;
                            end
                        end
                    end
                    ST_CMD: begin
                        if (scl_fall && cnt == BYTE_END) begin
                            cmd   <= shreg;
                            cnt   <= '0;
                            state <= ST_CMD_ACK;
                        end
                    end
                    ST_CMD_ACK: begin
                        if (scl_fall) state <= ST_DATA;
                    end
                    ST_DATA: begin
                        if (scl_fall && cnt == BYTE_END) begin
                            cnt   <= '0;
                            state <= ST_DATA_ACK;
                        end
                    end
                    ST_DATA_ACK: begin
                        if (scl_fall) begin
                            wr_en <= 1'b1;
                            state <= ST_HOLD;
                        end
                    end
                    ST_RD: begin
                        if (scl_fall) begin
                            if (cnt == LAST_TX) begin
                                state <= ST_HOLD;
                            end else begin
                                tx  <= {tx[6:0], 1'b0};
                                cnt <= cnt + 4'd1;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe = 1'b0;
        unique case (state)
            ST_ADDR_ACK, ST_CMD_ACK, ST_DATA_ACK: sda_oe = 1'b1;
            ST_RD:                                sda_oe = ~tx[7];
            default:                              sda_oe = 1'b0;
        endcase
    end

    assign wr_sel  = cmd;
    assign wr_data = shreg[CODE_W-1:0];

    // SDA drive moves only after a falling SCL edge or a bus condition
    p_sda_on_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> ($past(scl_fall) || $past(bus_start) || $past(bus_stop)));

    // register update is launched by a falling SCL edge with no STOP
    p_commit_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(scl_fall) && !$past(bus_stop) && !$past(bus_start)));

    // narrow port: upper returned bits are driven as 0
    p_narrow_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD && more_dac && cnt < HALF) |-> sda_oe);
endmodule

// File: rtl/dacx_regs.sv
module dacx_regs #(
    parameter int CODE_W = 8,
    parameter int N_CH   = 8,
    parameter int EXP_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     more_dac,
    input  logic                     wr_en,
    input  logic [7:0]               wr_sel,
    input  logic [CODE_W-1:0]        wr_data,
    input  logic [EXP_W-1:0]         exp_in,
    output logic [EXP_W-1:0]         rd_word,
    output logic [EXP_W-1:0]         exp_out,
    output logic [N_CH*CODE_W-1:0]   dac_code
);
    localparam int NARROW_CH  = N_CH / 2;
    localparam int NARROW_EXP = EXP_W / 2;
    localparam int PAD_W      = EXP_W - NARROW_EXP;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        localparam bit IN_NARROW = (g < NARROW_CH);
        logic [CODE_W-1:0] code_q;
        logic              hit;
        assign hit = wr_en && (wr_sel == 8'(g + 1)) && (more_dac || IN_NARROW);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   code_q <= '0;
            else if (hit) code_q <= wr_data;
        end
        assign dac_code[g*CODE_W +: CODE_W] = code_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_out <= '0;
        end else if (wr_en && wr_sel == 8'd0) begin
            exp_out <= more_dac ? {{PAD_W{1'b0}}, wr_data[NARROW_EXP-1:0]}
                                : wr_data[EXP_W-1:0];
        end
    end

    assign rd_word = more_dac ? {{PAD_W{1'b0}}, exp_in[NARROW_EXP-1:0]} : exp_in;

    p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && more_dac && wr_sel == 8'd0) |=> (exp_out[EXP_W-1:NARROW_EXP] == '0));

    p_code_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((dac_code != $past(dac_code)) || (exp_out != $past(exp_out))) |-> $past(wr_en));
endmodule

// File: rtl/dacx_i2c_slave.sv
module dacx_i2c_slave #(
    parameter int              SEL_W   = 2,
    parameter logic [6-SEL_W:0] ADDR_HI = 5'b10110,
    parameter int              CODE_W  = 8,
    parameter int              N_CH    = 8,
    parameter int              EXP_W   = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe,
    input  logic [SEL_W-1:0]       addr_sel,
    input  logic                   more_dac,
    input  logic [EXP_W-1:0]       exp_in,
    output logic [EXP_W-1:0]       exp_out,
    output logic [N_CH*CODE_W-1:0] dac_code
);
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              bus_start;
    logic              bus_stop;
    logic              wr_en;
    logic [7:0]        wr_sel;
    logic [CODE_W-1:0] wr_data;
    logic [EXP_W-1:0]  rd_word;

    dacx_line_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    dacx_ctrl #(
        .SEL_W   (SEL_W),
        .HI_W    (7 - SEL_W),
        .ADDR_HI (ADDR_HI),
        .CODE_W  (CODE_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .addr_sel  (addr_sel),
        .more_dac  (more_dac),
        .rd_word   (rd_word),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data)
    );

    dacx_regs #(
        .CODE_W (CODE_W),
        .N_CH   (N_CH),
        .EXP_W  (EXP_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .more_dac (more_dac),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .exp_in   (exp_in),
        .rd_word  (rd_word),
        .exp_out  (exp_out),
        .dac_code (dac_code)
    );
endmodule

// File: tb/dacx_i2c_slave_tb.sv
`timescale 1ns/1ps
module dacx_i2c_slave_tb_top;
    localparam logic [6:0] OWN   = 7'b1011001;
    localparam logic [6:0] OTHER = 7'b1011010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic [1:0]  asel = 2'b01;
    logic        more = 1'b0;
    logic [7:0]  ein = 8'h00;
    logic        sda_oe;
    logic [7:0]  exp_out;
    logic [63:0] dac_code;
    wire         sda_bus = m_sda & ~sda_oe;

    always #2 clk = ~clk;

    dacx_i2c_slave dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (m_scl),
        .sda_i    (sda_bus),
        .sda_oe   (sda_oe),
        .addr_sel (asel),
        .more_dac (more),
        .exp_in   (ein),
        .exp_out  (exp_out),
        .dac_code (dac_code)
    );

    int   checks = 0;
    int   errors = 0;
    bit   cmp_en = 1'b0;
    bit   quiet = 1'b0;
    int   quiet_hits = 0;
    bit   done = 1'b0;
    logic [7:0] m_dac [8];
    logic [7:0] m_exp;
    bit   pend = 1'b0;
    logic [7:0] pend_cmd, pend_data;

    function automatic logic [63:0] model_flat();
        logic [63:0] f;
        for (int i = 0; i < 8; i++) f[i*8 +: 8] = m_dac[i];
        return f;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the behavioural model (R4 R5 R6 R9 R10)
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            check("R4 model codes", dac_code, model_flat());
            check("R6 model port", {56'h0, exp_out}, {56'h0, m_exp});
        end
        if (quiet && sda_oe) quiet_hits++;
    end

    task automatic apply_pending();
        if (pend) begin
            if (pend_cmd == 8'd0)
                m_exp = more ? {4'h0, pend_data[3:0]} : pend_data;
            else if (pend_cmd <= (more ? 8'd8 : 8'd4))
                m_dac[pend_cmd - 8'd1] = pend_data;
        end
        pend = 1'b0;
    endtask

    task automatic q();
        repeat (10) @(negedge clk);
    endtask

    task automatic start_c();
        m_sda = 1'b1; q(); m_scl = 1'b1; q(); m_sda = 1'b0; q(); m_scl = 1'b0; q();
    endtask

    task automatic stop_c();
        m_sda = 1'b0; q(); m_scl = 1'b1; q(); m_sda = 1'b1; q();
    endtask

    task automatic wbit(input logic b);
        m_sda = b; q(); m_scl = 1'b1; q(); q(); m_scl = 1'b0; q();
    endtask

    task automatic rbit(output logic b, input bit commit);
        m_sda = 1'b1; q(); m_scl = 1'b1; q(); b = sda_bus; q();
        if (commit) cmp_en = 1'b0;
        m_scl = 1'b0; q();
        if (commit) begin apply_pending(); cmp_en = 1'b1; end
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack, input bit commit);
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(ack, commit);
    endtask

    task automatic recv_byte(output logic [7:0] v, input bit swap, input logic [7:0] nv);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b, 1'b0);
            v[i] = b;
            if (swap && i == 7) ein = nv;
        end
        wbit(1'b1);
    endtask

    task automatic write_xfer(input logic [6:0] a, input logic [7:0] c, input logic [7:0] d,
                              output logic k0, output logic k1, output logic k2);
        start_c();
        send_byte({a, 1'b0}, k0, 1'b0);
        send_byte(c, k1, 1'b0);
        pend = (a == OWN); pend_cmd = c; pend_data = d;
        send_byte(d, k2, 1'b1);
        stop_c();
        pend = 1'b0;
    endtask

    task automatic read_xfer(input logic [6:0] a, output logic k0, output logic [7:0] v,
                             input bit swap, input logic [7:0] nv);
        start_c();
        send_byte({a, 1'b1}, k0, 1'b0);
        recv_byte(v, swap, nv);
        stop_c();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic k0, k1, k2;
        logic [7:0] rv;
        for (int i = 0; i < 8; i++) m_dac[i] = 8'h00;
        m_exp = 8'h00;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        q();
        // R1 reset state
        check("R1 codes", dac_code, 64'h0);
        check("R1 port", {56'h0, exp_out}, 64'h0);
        check("R1 sda", {63'h0, sda_oe}, 64'h0);
        cmp_en = 1'b1;

        // R2 R4 narrow channel writes
        write_xfer(OWN, 8'd1, 8'h3C, k0, k1, k2);
        check("R2 ack addr/sel/data", {61'h0, k0, k1, k2}, 64'h0);
        check("R4 ch1", {56'h0, dac_code[7:0]}, 64'h3C);
        write_xfer(OWN, 8'd4, 8'hF0, k0, k1, k2);
        check("R4 ch4", {56'h0, dac_code[31:24]}, 64'hF0);

        // R5 R10 channel 5 is out of range when narrow
        write_xfer(OWN, 8'd5, 8'h77, k0, k1, k2);
        check("R10 ack sel 5", {61'h0, k0, k1, k2}, 64'h0);
        check("R5 ch5 untouched", {56'h0, dac_code[39:32]}, 64'h00);
        write_xfer(OWN, 8'h20, 8'h12, k0, k1, k2);
        check("R10 ack sel 0x20", {61'h0, k0, k1, k2}, 64'h0);

        // R6 wide port write
        write_xfer(OWN, 8'd0, 8'hAB, k0, k1, k2);
        check("R6 wide port", {56'h0, exp_out}, 64'hAB);

        // R3 foreign address
        quiet = 1'b1;
        write_xfer(OTHER, 8'd2, 8'h55, k0, k1, k2);
        quiet = 1'b0;
        check("R3 no ack", {63'h0, k0}, 64'h1);
        check("R3 sda idle", quiet_hits, 0);
        check("R3 ch2", {56'h0, dac_code[15:8]}, 64'h00);

        // R5 R6 eight-channel strap
        more = 1'b1; q();
        write_xfer(OWN, 8'd8, 8'h81, k0, k1, k2);
        check("R5 ch8", {56'h0, dac_code[63:56]}, 64'h81);
        write_xfer(OWN, 8'd5, 8'h55, k0, k1, k2);
        check("R5 ch5", {56'h0, dac_code[39:32]}, 64'h55);
        write_xfer(OWN, 8'd9, 8'h66, k0, k1, k2);
        check("R10 ack sel 9", {61'h0, k0, k1, k2}, 64'h0);
        write_xfer(OWN, 8'd0, 8'hDE, k0, k1, k2);
        check("R6 narrow port", {56'h0, exp_out}, 64'h0E);

        // R7 narrow read
        ein = 8'hA5;
        read_xfer(OWN, k0, rv, 1'b0, 8'h00);
        check("R2 read ack", {63'h0, k0}, 64'h0);
        check("R7 narrow read", {56'h0, rv}, 64'h05);

        // R7 R8 wide reads
        more = 1'b0; q();
        ein = 8'h96;
        read_xfer(OWN, k0, rv, 1'b0, 8'h00);
        check("R7 wide read", {56'h0, rv}, 64'h96);
        ein = 8'h3C;
        read_xfer(OWN, k0, rv, 1'b1, 8'hC3);
        check("R8 coherent read", {56'h0, rv}, 64'h3C);

        // R9 aborts: STOP inside data byte, and STOP after selection ack
        start_c();
        send_byte({OWN, 1'b0}, k0, 1'b0);
        send_byte(8'd2, k1, 1'b0);
        wbit(1'b1); wbit(1'b0); wbit(1'b1);
        stop_c();
        check("R9 ch2 after abort", {56'h0, dac_code[15:8]}, 64'h00);
        start_c();
        send_byte({OWN, 1'b0}, k0, 1'b0);
        send_byte(8'd1, k1, 1'b0);
        stop_c();
        check("R9 ch1 kept", {56'h0, dac_code[7:0]}, 64'h3C);

        // R11 repeated START mid data then full frame
        start_c();
        send_byte({OWN, 1'b0}, k0, 1'b0);
        send_byte(8'd1, k1, 1'b0);
        wbit(1'b0); wbit(1'b1); wbit(1'b1); wbit(1'b0);
        write_xfer(OWN, 8'd3, 8'h99, k0, k1, k2);
        check("R11 ack after restart", {61'h0, k0, k1, k2}, 64'h0);
        check("R11 ch3", {56'h0, dac_code[23:16]}, 64'h99);
        check("R11 ch1 kept", {56'h0, dac_code[7:0]}, 64'h3C);

        q();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule